// File: doc/BRIEF.md
# Time-Aligned Periodic Clock Output

This block produces a square wave on an output pin whose edges fall on exact points of a free-running 64-bit time counter. Software programs a start time and a half-period, both 64-bit values split into 32-bit halves, plus a small control word and a pin configuration word. Once enabled, the block compares the counter with a running target. Each time the counter reaches the target, the pin level flips and the target moves forward by the period. Because the target is advanced by adding the period to itself, late compares do not accumulate drift. If the counter has run ahead of the target, the block emits one toggle per cycle until the target catches up.

The start time can be taken as an absolute instant, which lets software line up edges with whole seconds. It can also be taken relative to the moment of enabling, in which case the first edge lands one period after arming. Each toggle can raise a one-cycle interrupt pulse. The level reaches the pin only when the pin is configured as an output and routed to this function. The register bus is a plain write strobe with a combinational read port; every write is taken in the cycle it is presented.

Top module: `clkout_gen`

## Requirements
- R1: After reset every register reads zero, and `pin_o`, `pin_oe` and `pin_irq` are low.
- R2: Register map by word address: 0 = control (bit 0 enable, bit 1 align-to-start, bit 2 edge interrupt enable; bits 31..3 read zero); 1 = start low half; 2 = start high half; 3 = period low half; 4 = period high half; 5 = pin config (bit 0 output direction, bit 1 route to clock function; other bits read zero). Addresses 6 and 7 read zero, and writes to them change nothing.
- R3: While enable is clear, the internal level is held low, no compare occurs and `pin_irq` stays low, whatever the counter does.
- R4: With align-to-start set, the first clock edge after enabling arms the target with the start value. After that, the level flips on the clock edge that samples the counter at or above the target.
- R5: After every toggle, the target becomes the old target plus the period, independent of the counter value at the time. A counter that is far ahead therefore produces one toggle per cycle until the target passes it.
- R6: With align-to-start clear, arming loads the target with the counter value sampled at arming plus the period.
- R7: `pin_irq` is high for exactly the cycle in which the level has just flipped, and only when edge interrupt enable is set. Clearing enable returns the level low without an interrupt.
- R8: `pin_oe` equals the direction bit. `pin_o` equals the level when both pin config bits are set, and is 0 otherwise.
- R9: A register write takes effect from the following cycle. A compare hit in the same cycle as a period write advances the target with the old period.
- R10: The compare is a full 64-bit unsigned compare, correct across a carry between the 32-bit halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | 64 | Current value of the time counter |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address for write and read |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Register read data (combinational) |
| pin_o | output | 1 | Pin output level |
| pin_oe | output | 1 | Pin output enable (direction) |
| pin_irq | output | 1 | One-cycle pulse per pin toggle |

## Verification
A compare hit and a register write can land on the same clock edge. The case of interest is a new period being written exactly when the counter reaches the target. The bench provokes this by predicting the hit cycle from its model and presenting a period write in that cycle. It then judges the spacing of the next edge, which must follow the old period for one interval and the new period only after that. The same collision appears less predictably during the random phase, where writes to control, start and period fall at arbitrary points relative to running compares.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  typedef struct packed {
    logic irq_en;
    logic align;
    logic en;
  } ctrl_t;

  typedef struct packed {
    logic route;
    logic dir;
  } pincfg_t;

  localparam int CTRL_W   = $bits(ctrl_t);
  localparam int PINCFG_W = $bits(pincfg_t);
  localparam int CTRL_ADDR = 0;
  localparam int START_BASE = 1;
endpackage

// File: rtl/clkout_regs.sv
module clkout_regs
  import clkout_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wr_data,
  output logic [BUS_W-1:0]  rd_data,
  output ctrl_t             ctrl,
  output pincfg_t           pincfg,
  output logic [TIME_W-1:0] start,
  output logic [TIME_W-1:0] period
);
  localparam int HALVES     = TIME_W / BUS_W;
  localparam int PER_BASE   = START_BASE + HALVES;
  localparam int PINCFG_ADR = PER_BASE + HALVES;

  ctrl_t             ctrl_q;
  pincfg_t           pincfg_q;
  logic [TIME_W-1:0] start_q;
  logic [TIME_W-1:0] period_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      pincfg_q <= '0;
      start_q  <= '0;
      period_q <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(CTRL_ADDR))
        ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (addr == ADDR_W'(PINCFG_ADR))
        pincfg_q <= pincfg_t'(wr_data[PINCFG_W-1:0]);
      for (int h = 0; h < HALVES; h++) begin
        if (addr == ADDR_W'(START_BASE + h))
          start_q[h*BUS_W +: BUS_W] <= wr_data;
        if (addr == ADDR_W'(PER_BASE + h))
          period_q[h*BUS_W +: BUS_W] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == ADDR_W'(CTRL_ADDR))
      rd_data = BUS_W'(ctrl_q);
    if (addr == ADDR_W'(PINCFG_ADR))
      rd_data = BUS_W'(pincfg_q);
    for (int h = 0; h < HALVES; h++) begin
      if (addr == ADDR_W'(START_BASE + h))
        rd_data = start_q[h*BUS_W +: BUS_W];
      if (addr == ADDR_W'(PER_BASE + h))
        rd_data = period_q[h*BUS_W +: BUS_W];
    end
  end

  assign ctrl   = ctrl_q;
  assign pincfg = pincfg_q;
  assign start  = start_q;
  assign period = period_q;
endmodule

// File: rtl/clkout_sched.sv
module clkout_sched #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              align,
  input  logic              irq_en,
  input  logic [TIME_W-1:0] start,
  input  logic [TIME_W-1:0] period,
  input  logic [TIME_W-1:0] now,
  output logic              level,
  output logic              irq,
  output logic [TIME_W-1:0] target
);
  logic              armed_q;
  logic              level_q;
  logic              irq_q;
  logic [TIME_W-1:0] tgt_q;
  logic              hit;

  assign hit = en && armed_q && (now >= tgt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      level_q <= 1'b0;
      irq_q   <= 1'b0;
      tgt_q   <= '0;
    end else begin
      irq_q <= 1'b0;
      if (!en) begin
        armed_q <= 1'b0;
        level_q <= 1'b0;
      end else if (!armed_q) begin
        armed_q <= 1'b1;
        tgt_q   <= align ? start : now + period;
      end else if (hit) begin
        level_q <= ~level_q;
        tgt_q   <= tgt_q + period;
        irq_q   <= irq_en;
      end
    end
  end

  assign level  = level_q;
  assign irq    = irq_q;
  assign target = tgt_q;
endmodule

// File: rtl/clkout_pinmux.sv
module clkout_pinmux (
  input  logic dir,
  input  logic route,
  input  logic level,
  output logic pin_o,
  output logic pin_oe
);
  assign pin_oe = dir;
  assign pin_o  = dir & route & level;
endmodule

// File: rtl/clkout_gen.sv
module clkout_gen
  import clkout_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] time_now,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wr_data,
  output logic [BUS_W-1:0]  reg_rd_data,
  output logic              pin_o,
  output logic              pin_oe,
  output logic              pin_irq
);
  ctrl_t             ctrl_w;
  pincfg_t           pincfg_w;
  logic [TIME_W-1:0] start_w;
  logic [TIME_W-1:0] period_w;
  logic              level_w;
  logic [TIME_W-1:0] target_w;
  logic              en_w;
  logic              irq_en_w;

  clkout_regs #(.TIME_W(TIME_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .addr    (reg_addr),
    .wr_data (reg_wr_data),
    .rd_data (reg_rd_data),
    .ctrl    (ctrl_w),
    .pincfg  (pincfg_w),
    .start   (start_w),
    .period  (period_w)
  );

  assign en_w     = ctrl_w.en;
  assign irq_en_w = ctrl_w.irq_en;

  clkout_sched #(.TIME_W(TIME_W)) u_sched (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en_w),
    .align  (ctrl_w.align),
    .irq_en (irq_en_w),
    .start  (start_w),
    .period (period_w),
    .now    (time_now),
    .level  (level_w),
    .irq    (pin_irq),
    .target (target_w)
  );

  clkout_pinmux u_pin (
    .dir    (pincfg_w.dir),
    .route  (pincfg_w.route),
    .level  (level_w),
    .pin_o  (pin_o),
    .pin_oe (pin_oe)
  );
endmodule

// File: rtl/clkout_gen_chk.sv
module clkout_gen_chk #(
  parameter int TIME_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              irq_en,
  input logic              level,
  input logic [TIME_W-1:0] target,
  input logic [TIME_W-1:0] period,
  input logic              pin_o,
  input logic              pin_oe,
  input logic              pin_irq
);
  assert_low_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !level);

  assert_no_irq_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pin_irq);

  assert_irq_marks_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pin_irq |-> (level != $past(level)));

  assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pin_irq |-> $past(irq_en));

  assert_target_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && (level != $past(level))) |-> (target == $past(target) + $past(period)));

  assert_pin_off_when_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> !pin_o);
endmodule

bind clkout_gen clkout_gen_chk #(.TIME_W(TIME_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en_w),
  .irq_en  (irq_en_w),
  .level   (level_w),
  .target  (target_w),
  .period  (period_w),
  .pin_o   (pin_o),
  .pin_oe  (pin_oe),
  .pin_irq (pin_irq)
);

// File: tb/sim_clkout_gen.sv
module sim_clkout_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] time_now = '0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic        pin_o, pin_oe, pin_irq;

  int checks = 0;
  int fails  = 0;
  logic [63:0] inc = 64'd1;

  // requirement-level reference state
  logic [2:0]  m_ctrl = '0;
  logic [1:0]  m_pcfg = '0;
  logic [63:0] m_start = '0, m_per = '0, m_tgt = '0;
  logic        m_armed = 1'b0, m_level = 1'b0, m_irq = 1'b0;

  clkout_gen u0 (
    .clk(clk), .rst_n(rst_n), .time_now(time_now), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
    .pin_o(pin_o), .pin_oe(pin_oe), .pin_irq(pin_irq)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: m_read = {29'd0, m_ctrl};
      3'd1: m_read = m_start[31:0];
      3'd2: m_read = m_start[63:32];
      3'd3: m_read = m_per[31:0];
      3'd4: m_read = m_per[63:32];
      3'd5: m_read = {30'd0, m_pcfg};
      default: m_read = '0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = '0; m_pcfg = '0; m_start = '0; m_per = '0; m_tgt = '0;
      m_armed = 0; m_level = 0; m_irq = 0;
    end else begin
      m_irq = 0;
      if (!m_ctrl[0]) begin
        m_armed = 0; m_level = 0;
      end else if (!m_armed) begin
        m_armed = 1;
        m_tgt = m_ctrl[1] ? m_start : time_now + m_per;
      end else if (time_now >= m_tgt) begin
        m_level = ~m_level;
        m_tgt = m_tgt + m_per;
        m_irq = m_ctrl[2];
      end
      if (reg_wr_en) begin
        case (reg_addr)
          3'd0: m_ctrl = reg_wr_data[2:0];
          3'd1: m_start[31:0] = reg_wr_data;
          3'd2: m_start[63:32] = reg_wr_data;
          3'd3: m_per[31:0] = reg_wr_data;
          3'd4: m_per[63:32] = reg_wr_data;
          3'd5: m_pcfg = reg_wr_data[1:0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_out(input string tag);
    logic exp_o;
    exp_o = (m_pcfg[0] & m_pcfg[1]) ? m_level : 1'b0;
    chk({tag, " pin_o"}, 64'(pin_o), 64'(exp_o));
    chk({tag, " pin_oe"}, 64'(pin_oe), 64'(m_pcfg[0]));
    chk({tag, " pin_irq"}, 64'(pin_irq), 64'(m_irq));
  endtask

  task automatic tick(input string tag, input logic w, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    chk_out(tag);
    reg_wr_en = w; reg_addr = a; reg_wr_data = d;
    time_now = time_now + inc;
  endtask

  task automatic run(input string tag, input int n);
    for (int i = 0; i < n; i++) tick(tag, 1'b0, 3'd0, 32'd0);
  endtask

  task automatic rdchk(input string tag, input logic [2:0] a);
    @(negedge clk);
    chk_out(tag);
    reg_wr_en = 0; reg_addr = a;
    #1;
    chk({tag, " rd"}, 64'(reg_rd_data), 64'(m_read(a)));
  endtask

  task automatic wr64(input string tag, input logic [2:0] base, input logic [63:0] v);
    tick(tag, 1'b1, base, v[31:0]);
    tick(tag, 1'b1, base + 3'd1, v[63:32]);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int hits;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 8; a++) rdchk("R1 reset", 3'(a));

    // R2 register map and ignored addresses
    tick("R2", 1'b1, 3'd0, 32'hFFFF_FFF8);
    for (int a = 1; a < 6; a++) tick("R2", 1'b1, 3'(a), $urandom);
    tick("R2", 1'b1, 3'd6, 32'hDEAD_BEEF);
    tick("R2", 1'b1, 3'd7, 32'h1234_5678);
    for (int a = 0; a < 8; a++) rdchk("R2 readback", 3'(a));
    tick("R2", 1'b1, 3'd0, 32'd0);

    // R8 pin routing combinations while toggling
    inc = 64'd4;
    wr64("R8", 3'd3, 64'd10);
    tick("R8", 1'b1, 3'd0, 32'd1);
    for (int c = 0; c < 4; c++) begin
      tick("R8", 1'b1, 3'd5, 32'(c));
      run("R8", 20);
    end

    // R3 disabled: no toggle, no irq
    tick("R3", 1'b1, 3'd0, 32'd4);
    run("R3", 40);

    // R4 and R5: aligned start, random counter steps
    tick("R4", 1'b1, 3'd5, 32'd3);
    wr64("R4", 3'd1, time_now + 64'd200);
    wr64("R5", 3'd3, 64'd37);
    tick("R4", 1'b1, 3'd0, 32'd7);
    for (int i = 0; i < 300; i++) begin
      inc = 64'($urandom_range(1, 9));
      tick("R4 R5 R7", 1'b0, 3'd0, 32'd0);
    end

    // R5 catch-up: start far in the past
    tick("R5", 1'b1, 3'd0, 32'd0);
    inc = 64'd2;
    wr64("R5", 3'd1, time_now - 64'd500);
    wr64("R5", 3'd3, 64'd25);
    tick("R5", 1'b1, 3'd0, 32'd7);
    run("R5 catch-up", 60);

    // R6 relative start, irq disabled (R7)
    tick("R6", 1'b1, 3'd0, 32'd0);
    wr64("R6", 3'd3, 64'd19);
    tick("R6", 1'b1, 3'd0, 32'd1);
    for (int i = 0; i < 200; i++) begin
      inc = 64'($urandom_range(1, 6));
      tick("R6 R7", 1'b0, 3'd0, 32'd0);
    end
    tick("R7 disable", 1'b1, 3'd0, 32'd0);
    run("R7 disable", 5);

    // R10 carry across halves
    tick("R10", 1'b0, 3'd0, 32'd0);
    time_now = 64'h0000_0001_FFFF_FF00;
    inc = 64'd3;
    wr64("R10", 3'd1, 64'h0000_0002_0000_0010);
    wr64("R10", 3'd3, 64'd20);
    tick("R10", 1'b1, 3'd0, 32'd7);
    run("R10", 200);

    // R9 period write landing on a compare hit
    hits = 0;
    inc = 64'd1;
    tick("R9", 1'b1, 3'd0, 32'd0);
    wr64("R9", 3'd3, 64'd11);
    tick("R9", 1'b1, 3'd0, 32'd5);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      chk_out("R9 collision");
      reg_wr_en = 0;
      time_now = time_now + inc;
      if (m_ctrl[0] && m_armed && time_now >= m_tgt && hits < 6) begin
        reg_wr_en = 1; reg_addr = 3'd3;
        reg_wr_data = 32'($urandom_range(5, 30));
        hits++;
      end
    end
    chk("R9 collisions provoked", 64'(hits), 64'd6);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [2:0]  a;
      logic [31:0] d;
      inc = 64'($urandom_range(1, 8));
      a = 3'($urandom_range(0, 7));
      case (a)
        3'd1: d = time_now[31:0] + 32'($urandom_range(0, 300));
        3'd2: d = time_now[63:32];
        3'd3: d = 32'($urandom_range(1, 60));
        3'd4: d = 32'd0;
        default: d = $urandom;
      endcase
      tick("R3 R5 R7 R8 R9 random", ($urandom_range(0, 9) == 0), a, d);
    end
    for (int a = 0; a < 8; a++) rdchk("R2 final", 3'(a));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule